// File: doc/BRIEF.md
# Coincident-Current Core Memory Cycle Sequencer

This block runs a magnetic core array one access at a time. A request carries an address, a two-bit cycle type and write data. The block first runs a read half-cycle. In that half it energizes one X line and one Y line together and drives the addressed word toward 0. The sense response is captured as the old word.

Sensing erases the word, so a write half-cycle at the same address always follows. In the write half every selected core is driven toward 1. Bits that must stay 0 are held back by their inhibit line; there is no per-bit write enable. The data put back depends on the cycle type: the word just read, new data supplied with the request, or modified data supplied later while the block waits between the halves.

A simulation-only plane model inside the top turns drive events into sense pulses. A core that flips during the read gives a pulse (sensed as 1). A core that was already 0 gives none. A core reached by only one of its two lines is never disturbed.

Top module: `core_seq_top`

## Requirements
- R1: At any clock at most one X line and at most one Y line are driven, and X and Y are either both driven or both quiet. The driven lines are X = address bits [XBITS-1:0] and Y = the upper address bits.
- R2: The read half lasts HALF_CLKS clocks with read_strobe high. sense_en is high for exactly one clock of it, in its second-to-last clock.
- R3: rd_data returns the word stored at the address before the cycle, with every sensed bit latched as 1.
- R4: Each read half is followed by a write half at the same address, possibly after a modify pause. inhibit is nonzero only during the write half, where it equals the bitwise inverse of the word written back.
- R5: Cycle type 2'b00 (restore) writes back the word read, so the stored word is unchanged.
- R6: Cycle type 2'b01 (replace) stores req_wdata, while rd_data still reports the previous contents.
- R7: Cycle type 2'b10 (modify) enters a pause after the read half. In the pause mod_wait is high, no line is driven and rd_data already holds the old word. The block stays there until mod_valid, then stores mod_wdata.
- R8: Cycle type 2'b11 behaves exactly as restore.
- R9: done is high for exactly one clock, the first clock after the write half. Without a pause the request is sampled at one edge and done appears 2*HALF_CLKS edges later.
- R10: req_ready is high only while idle. A request presented while busy is ignored and changes no stored word.
- R11: A cycle changes only the addressed word. Words that share just its X line or just its Y line keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a cycle (taken only when req_ready) |
| req_addr | input | XBITS+YBITS | Word address |
| req_type | input | 2 | 00 restore, 01 replace, 10 modify, 11 restore |
| req_wdata | input | WIDTH | New data for replace |
| mod_valid | input | 1 | Modified data present (modify pause) |
| mod_wdata | input | WIDTH | Modified data |
| req_ready | output | 1 | Idle, request accepted |
| mod_wait | output | 1 | Paused between halves for modified data |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | WIDTH | Word read in the last cycle |
| x_drive | output | 2**XBITS | X half-select strobes |
| y_drive | output | 2**YBITS | Y half-select strobes |
| read_strobe | output | 1 | Drive polarity toward 0 (read half) |
| inhibit | output | WIDTH | Per-bit inhibit strobes (write half) |
| sense_en | output | 1 | Sense latch window |

## Verification
The assertions assume that req_type is always one of the four defined codes. They also assume mod_valid is only meaningful during a modify pause, so a stray pulse while idle or in another phase has no effect. The stimulus raises req_valid only at a falling edge, for one clock, and issues mod_valid only after it has seen mod_wait. One deliberate request is placed in the middle of a busy cycle, to show that it is dropped. Read values come from a word-by-word mirror the bench keeps from the cycle types it issued.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;
  typedef enum logic [1:0] {
    CT_RESTORE = 2'b00,
    CT_REPLACE = 2'b01,
    CT_MODIFY  = 2'b10,
    CT_ALIAS   = 2'b11
  } cyc_type_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;
endpackage

// File: rtl/core_line_decode.sv
module core_line_decode #(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0]      idx,
  input  logic                  en,
  output logic [(1<<IDX_W)-1:0] lines
);
  localparam int NLINES = 1 << IDX_W;
  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign lines[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/core_seq_ctrl.sv
module core_seq_ctrl
  import core_seq_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int ADDR_W    = 4,
  parameter int HALF_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_type,
  input  logic [WIDTH-1:0]  req_wdata,
  input  logic              mod_valid,
  input  logic [WIDTH-1:0]  mod_wdata,
  input  logic [WIDTH-1:0]  sense_bits,
  output logic              req_ready,
  output logic              drive_on,
  output logic [ADDR_W-1:0] drive_addr,
  output logic              read_strobe,
  output logic [WIDTH-1:0]  inhibit,
  output logic              sense_en,
  output logic [WIDTH-1:0]  rd_data,
  output logic              done,
  output logic              mod_wait
);
  localparam int CW = $clog2(HALF_CLKS + 1);
  localparam logic [CW-1:0] LAST_CNT  = CW'(HALF_CLKS - 1);
  localparam logic [CW-1:0] SENSE_CNT = CW'(HALF_CLKS - 2);

  // Word to be written back once the read half is over.
  function automatic logic [WIDTH-1:0] writeback_word(
    input logic [1:0] kind, input logic [WIDTH-1:0] old_word,
    input logic [WIDTH-1:0] new_word);
    return (kind == CT_REPLACE) ? new_word : old_word;
  endfunction

  phase_e            phase;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        type_q;
  logic [WIDTH-1:0]  wbuf;
  logic [WIDTH-1:0]  rd_q;
  logic              done_q;

  wire half_end = (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      type_q <= CT_RESTORE;
      wbuf   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          type_q <= req_type;
          wbuf   <= req_wdata;
          cnt    <= '0;
          phase  <= PH_READ;
        end
        PH_READ: begin
          if (sense_en) rd_q <= sense_bits;
          if (half_end) begin
            cnt <= '0;
            if (type_q == CT_MODIFY) phase <= PH_HOLD;
            else begin
              wbuf  <= writeback_word(type_q, rd_q, wbuf);
              phase <= PH_WRITE;
            end
          end else cnt <= cnt + 1'b1;
        end
        PH_HOLD: if (mod_valid) begin
          wbuf  <= mod_wdata;
          phase <= PH_WRITE;
        end
        PH_WRITE: begin
          if (half_end) begin
            cnt    <= '0;
            phase  <= PH_IDLE;
            done_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign req_ready   = (phase == PH_IDLE);
  assign drive_on    = (phase == PH_READ) || (phase == PH_WRITE);
  assign drive_addr  = addr_q;
  assign read_strobe = (phase == PH_READ);
  assign sense_en    = (phase == PH_READ) && (cnt == SENSE_CNT);
  assign inhibit     = (phase == PH_WRITE) ? ~wbuf : '0;
  assign mod_wait    = (phase == PH_HOLD);
  assign rd_data     = rd_q;
  assign done        = done_q;
endmodule

// File: rtl/core_plane_model.sv
module core_plane_model #(
  parameter int WIDTH = 8,
  parameter int XBITS = 2,
  parameter int YBITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<XBITS)-1:0] x_drive,
  input  logic [(1<<YBITS)-1:0] y_drive,
  input  logic                  read_strobe,
  input  logic [WIDTH-1:0]      inhibit,
  output logic [WIDTH-1:0]      sense
);
  localparam int XL    = 1 << XBITS;
  localparam int DEPTH = 1 << (XBITS + YBITS);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] flip_hold;
  logic [WIDTH-1:0] sel_word;
  logic             sel_hit;

  always_comb begin
    sel_word = '0;
    sel_hit  = 1'b0;
    for (int w = 0; w < DEPTH; w++) begin
      if (x_drive[w % XL] && y_drive[w / XL]) begin
        sel_hit  = 1'b1;
        sel_word = mem[w];
      end
    end
  end

  // Flipping cores pulse for the rest of the read drive.
  assign sense = (read_strobe && sel_hit) ? (sel_word | flip_hold) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flip_hold <= '0;
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      flip_hold <= (read_strobe && sel_hit) ? (flip_hold | sel_word) : '0;
      for (int w = 0; w < DEPTH; w++) begin
        if (x_drive[w % XL] && y_drive[w / XL]) begin
          if (read_strobe) mem[w] <= '0;
          else             mem[w] <= mem[w] | ~inhibit;
        end
      end
    end
  end
endmodule

// File: rtl/core_seq_top.sv
module core_seq_top #(
  parameter int WIDTH     = 8,
  parameter int XBITS     = 2,
  parameter int YBITS     = 2,
  parameter int HALF_CLKS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [XBITS+YBITS-1:0]   req_addr,
  input  logic [1:0]               req_type,
  input  logic [WIDTH-1:0]         req_wdata,
  input  logic                     mod_valid,
  input  logic [WIDTH-1:0]         mod_wdata,
  output logic                     req_ready,
  output logic                     mod_wait,
  output logic                     done,
  output logic [WIDTH-1:0]         rd_data,
  output logic [(1<<XBITS)-1:0]    x_drive,
  output logic [(1<<YBITS)-1:0]    y_drive,
  output logic                     read_strobe,
  output logic [WIDTH-1:0]         inhibit,
  output logic                     sense_en
);
  localparam int ADDR_W = XBITS + YBITS;
  localparam int XL     = 1 << XBITS;
  localparam int YL     = 1 << YBITS;

  logic              drive_on;
  logic [ADDR_W-1:0] drive_addr;
  logic [WIDTH-1:0]  sense_bits;

  core_seq_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .HALF_CLKS(HALF_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_type(req_type), .req_wdata(req_wdata), .mod_valid(mod_valid),
    .mod_wdata(mod_wdata), .sense_bits(sense_bits), .req_ready(req_ready),
    .drive_on(drive_on), .drive_addr(drive_addr), .read_strobe(read_strobe),
    .inhibit(inhibit), .sense_en(sense_en), .rd_data(rd_data), .done(done),
    .mod_wait(mod_wait)
  );

  core_line_decode #(.IDX_W(XBITS)) u_xdec (
    .idx(drive_addr[XBITS-1:0]), .en(drive_on), .lines(x_drive));

  core_line_decode #(.IDX_W(YBITS)) u_ydec (
    .idx(drive_addr[ADDR_W-1:XBITS]), .en(drive_on), .lines(y_drive));

  core_plane_model #(.WIDTH(WIDTH), .XBITS(XBITS), .YBITS(YBITS)) u_plane (
    .clk(clk), .rst_n(rst_n), .x_drive(x_drive), .y_drive(y_drive),
    .read_strobe(read_strobe), .inhibit(inhibit), .sense(sense_bits));
endmodule

// File: rtl/core_seq_checker.sv
module core_seq_checker #(
  parameter int XL    = 4,
  parameter int YL    = 4,
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [XL-1:0]    x_drive,
  input logic [YL-1:0]    y_drive,
  input logic             read_strobe,
  input logic [WIDTH-1:0] inhibit,
  input logic             sense_en,
  input logic             done,
  input logic             req_ready,
  input logic             mod_wait
);
  assert_xy_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_drive) && $onehot0(y_drive) && ((x_drive != '0) == (y_drive != '0)));

  assert_sense_in_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |-> read_strobe && (x_drive != '0));

  assert_inhibit_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit != '0) |-> (x_drive != '0) && !read_strobe);

  assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_strobe) |-> mod_wait ||
      ((x_drive != '0) && x_drive == $past(x_drive) && y_drive == $past(y_drive)));

  assert_pause_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mod_wait |-> (x_drive == '0) && (inhibit == '0) && !req_ready);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (x_drive == '0) && !read_strobe && !mod_wait);
endmodule

bind core_seq_top core_seq_checker #(.XL(XL), .YL(YL), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .x_drive(x_drive), .y_drive(y_drive),
  .read_strobe(read_strobe), .inhibit(inhibit), .sense_en(sense_en),
  .done(done), .req_ready(req_ready), .mod_wait(mod_wait));

// File: tb/tb_core_seq_top.sv
module tb_core_seq_top;
  localparam int W = 8, XB = 2, YB = 2, H = 4;
  localparam int AW = XB + YB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mod_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_type = '0;
  logic [W-1:0] req_wdata = '0, mod_wdata = '0;
  logic req_ready, mod_wait, done, read_strobe, sense_en;
  logic [W-1:0] rd_data, inhibit;
  logic [(1<<XB)-1:0] x_drive;
  logic [(1<<YB)-1:0] y_drive;

  int checks = 0, fails = 0;
  logic [W-1:0] mirror [1<<AW];
  logic [W-1:0] expq [$];
  bit finished = 0;

  always #4 clk = ~clk;

  core_seq_top #(.WIDTH(W), .XBITS(XB), .YBITS(YB), .HALF_CLKS(H)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_type(req_type), .req_wdata(req_wdata), .mod_valid(mod_valid),
    .mod_wdata(mod_wdata), .req_ready(req_ready), .mod_wait(mod_wait),
    .done(done), .rd_data(rd_data), .x_drive(x_drive), .y_drive(y_drive),
    .read_strobe(read_strobe), .inhibit(inhibit), .sense_en(sense_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected read word at each done pulse.
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) chk(0, "R9 spurious done", 1, 0);
      else begin
        automatic logic [W-1:0] e = expq.pop_front();
        chk(rd_data == e, "R3 read word", rd_data, e);
      end
    end
    if (rst_n && done && done_prev) chk(0, "R9 done longer than one clock", 1, 0);
    done_prev = done;
  end

  // Driver: issue one cycle, track the mirror and timing.
  task automatic do_cycle(input logic [AW-1:0] a, input logic [1:0] t,
                          input logic [W-1:0] d, input logic [W-1:0] md,
                          input bit intrude);
    logic [W-1:0] old = mirror[a];
    logic [W-1:0] wb;
    int n = 0, rs = 0, se = 0;
    bit inh_seen = 0;
    wb = (t == 2'b01) ? d : (t == 2'b10) ? md : old;
    while (!req_ready) @(negedge clk);
    expq.push_back(old);
    mirror[a] = wb;
    req_valid = 1; req_addr = a; req_type = t; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!done) begin
      if (read_strobe) rs++;
      if (sense_en) se++;
      if (n == 2)
        chk(x_drive == (1 << a[XB-1:0]) && y_drive == (1 << a[AW-1:XB]),
            "R1 line select", {x_drive, y_drive},
            {4'(1 << a[XB-1:0]), 4'(1 << a[AW-1:XB])});
      if (intrude && n == 3) begin
        chk(!req_ready, "R10 ready low while busy", req_ready, 0);
        req_valid = 1; req_addr = a ^ 4'h1; req_type = 2'b01; req_wdata = 8'hEE;
      end
      if (intrude && n == 4) req_valid = 0;
      if (!inh_seen && x_drive != 0 && !read_strobe) begin
        inh_seen = 1;
        chk(inhibit == ~wb, "R4 inhibit equals inverse write-back", inhibit, ~wb);
      end
      if (mod_wait) begin
        chk(rd_data == old, "R7 old word held during pause", rd_data, old);
        repeat (3) begin
          @(negedge clk); n++;
          chk(mod_wait && x_drive == 0, "R7 pause holds", mod_wait, 1);
        end
        mod_valid = 1; mod_wdata = md;
        @(negedge clk); n++;
        mod_valid = 0;
        continue;
      end
      @(negedge clk); n++;
    end
    chk(rs == H, "R2 read half length", rs, H);
    chk(se == 1, "R2 single sense window", se, 1);
    if (t != 2'b10) chk(n == 2*H + 1, "R9 cycle length", n, 2*H + 1);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !done && x_drive == 0 && inhibit == 0 && rd_data == 0,
        "R10 reset idle state", {req_ready, done, rd_data}, {1'b1, 1'b0, 8'h00});
    do_cycle(4'd0, 2'b01, 8'hA5, 8'h00, 0);   // R6 replace
    do_cycle(4'd0, 2'b00, 8'h00, 8'h00, 0);   // R5 restore
    do_cycle(4'd0, 2'b00, 8'h00, 8'h00, 0);   // R5 restore keeps word
    do_cycle(4'd1, 2'b01, 8'h3C, 8'h00, 0);   // R11 shares Y line with 0
    do_cycle(4'd4, 2'b01, 8'hC3, 8'h00, 0);   // R11 shares X line with 0
    do_cycle(4'd0, 2'b00, 8'h00, 8'h00, 0);   // R11 word 0 intact
    do_cycle(4'd15, 2'b01, 8'hFF, 8'h00, 0);  // top address, all ones
    do_cycle(4'd15, 2'b01, 8'h00, 8'h00, 0);  // all zeros
    do_cycle(4'd15, 2'b00, 8'h00, 8'h00, 0);
    do_cycle(4'd1, 2'b11, 8'h77, 8'h00, 0);   // R8 code 11 restores
    do_cycle(4'd1, 2'b00, 8'h00, 8'h00, 0);   // R8 word unchanged
    do_cycle(4'd4, 2'b10, 8'h11, 8'h5A, 0);   // R7 modify
    do_cycle(4'd4, 2'b00, 8'h00, 8'h00, 0);   // R7 modified word stored
    do_cycle(4'd2, 2'b00, 8'h00, 8'h00, 1);   // R10 intruding request on addr 3
    do_cycle(4'd3, 2'b00, 8'h00, 8'h00, 0);   // R10 addr 3 still zero
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R9 every cycle completed", expq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule